// File: doc/BRIEF.md
# Front Panel Switch Loader

This block sits behind a maintenance panel that has two groups of touch switches. One group edits an address word and the other edits a data word. When a switch closes, the block works out which group the closure came from. It then fires a select pulse for that group, lasting a fixed number of clock cycles, and the two select pulses lock each other out. Alongside the select pulse it issues a burst of exactly `WIDTH` shift pulses. That burst rotates the new value serially into the chosen register: the old contents with every touched bit flipped.

With no select pulse active, the same serial engine can step the address register up by one or by two. It does this one bit per shift, least significant bit first, with a carry flop. A mode input chooses what the LED outputs show: either the panel's own address and data registers or an address and data pair taken from the bus.

The analog closure sensing and the LED drivers sit outside the block. Closures arrive as asynchronous levels and are synchronized inside.

Top module: `panel_switch_loader`

## Requirements
- R1: A closure is accepted only when `sense_en_n` is low, neither select pulse is active and no shift burst is running; any other closure changes neither register nor either select output.
- R2: An accepted closure in the address group (a rising edge on any bit of `addr_keys`) drives `addr_sel` high for exactly `SEL_CYCLES` consecutive cycles.
- R3: `addr_sel` and `data_sel` are never high together, and a closure in either group made while a select is active is ignored.
- R4: An accepted address closure produces exactly `WIDTH` cycles of `shift_addr`, one per clock and none on `shift_data`. Afterwards `panel_addr` equals its old value XOR the mask of newly closed keys, where key i flips bit i.
- R5: An accepted data closure behaves the same way on `data_sel`, `shift_data` and `panel_data`. `shift_data` is high only while `data_sel` is high, and `panel_data` changes only on shift cycles.
- R6: A request on `inc_one` or `inc_two` while idle adds 1 or 2 to `panel_addr` modulo 2^WIDTH, using `WIDTH` cycles of `shift_addr`. `inc_two` wins when both are high, a closure accepted in the same cycle wins over either, and `panel_addr` changes only on shift cycles.
- R7: When `disp_bus` is 0, `led_addr`/`led_data` show `panel_addr`/`panel_data`; when it is 1, they show `bus_addr`/`bus_data`.
- R8: A key held closed triggers once only: no new select pulse and no further change until the key is released and closed again.
- R9: If both groups show a new closure in the same cycle, only the address group is served.
- R10: After reset, both registers, both selects and both shift outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_en_n | input | 1 | Active-low enable for switch sensing |
| addr_keys | input | WIDTH | Address group closures, asynchronous levels |
| data_keys | input | WIDTH | Data group closures, asynchronous levels |
| inc_one | input | 1 | Request to add 1 to the address register |
| inc_two | input | 1 | Request to add 2 to the address register |
| disp_bus | input | 1 | LED source: 0 panel registers, 1 bus values |
| bus_addr | input | WIDTH | Address from the bus multiplexer |
| bus_data | input | WIDTH | Data from the bus multiplexer |
| addr_sel | output | 1 | Address select pulse |
| data_sel | output | 1 | Data select pulse |
| shift_addr | output | 1 | Shift pulse to the address register |
| shift_data | output | 1 | Shift pulse to the data register |
| busy | output | 1 | Serial burst in progress |
| panel_addr | output | WIDTH | Panel address register |
| panel_data | output | WIDTH | Panel data register |
| led_addr | output | WIDTH | Address shown on the LEDs |
| led_data | output | WIDTH | Data shown on the LEDs |

## Verification
Some properties hold on every cycle, and the assertions cover those. They check the select lockout and the exact length of each select pulse. They check that every burst is exactly `WIDTH` pulses wide and lands on one register only, and that data shifts stay inside a data select. They also check that neither register moves outside its own shift cycles. The values that come out of a burst can only be shown by the bench's scenarios, which compare against a behavioural model every clock. Those values are the XOR of the touched keys, the carry rippling through an all-ones increment, the address-over-data priority, ignored closures and the once-per-touch rule.

// File: rtl/psl_pkg.sv
package psl_pkg;

    localparam int PSL_WIDTH      = 16;
    localparam int PSL_SEL_CYCLES = 355000;

    typedef enum logic [1:0] {
        OP_LOAD_ADDR = 2'd0,
        OP_LOAD_DATA = 2'd1,
        OP_INCREMENT = 2'd2
    } psl_op_e;

    typedef struct packed {
        logic    go;
        psl_op_e op;
    } psl_req_t;

    // one-bit full adder: returns {carry_out, sum}
    function automatic logic [1:0] full_add(input logic a, input logic b, input logic cin);
        return {(a & b) | (a & cin) | (b & cin), a ^ b ^ cin};
    endfunction

endpackage

// File: rtl/psl_key_sync.sv
module psl_key_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] keys,
    output logic [WIDTH-1:0] rise
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic sync_q;
        logic last_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= keys[i];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end

        assign rise[i] = sync_q & ~last_q;
    end

endmodule

// File: rtl/psl_oneshot.sv
module psl_oneshot #(
    parameter int CYCLES = 355000
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic hold_clear,
    output logic active
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || hold_clear) begin
            active <= 1'b0;
            left_q <= '0;
        end else if (fire) begin
            active <= 1'b1;
            left_q <= CW'(CYCLES - 1);
        end else if (active) begin
            if (left_q == '0) begin
                active <= 1'b0;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/psl_serial_engine.sv
module psl_serial_engine
    import psl_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  psl_req_t         req,
    input  logic [WIDTH-1:0] operand,
    output logic             busy,
    output logic             shift_a,
    output logic             shift_d,
    output logic [WIDTH-1:0] a_reg,
    output logic [WIDTH-1:0] d_reg
);

    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    psl_op_e          op_q;
    logic [WIDTH-1:0] opnd_q;
    logic [CNT_W-1:0] step_q;
    logic             carry_q;

    logic             cur_bit;
    logic [1:0]       add_out;
    logic             new_bit;

    always_comb begin
        cur_bit = (op_q == OP_LOAD_DATA) ? d_reg[0] : a_reg[0];
        add_out = full_add(cur_bit, opnd_q[0], carry_q);
        new_bit = (op_q == OP_INCREMENT) ? add_out[0] : (cur_bit ^ opnd_q[0]);
    end

    assign shift_a = busy && (op_q != OP_LOAD_DATA);
    assign shift_d = busy && (op_q == OP_LOAD_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            op_q    <= OP_LOAD_ADDR;
            opnd_q  <= '0;
            step_q  <= '0;
            carry_q <= 1'b0;
            a_reg   <= '0;
            d_reg   <= '0;
        end else if (!busy) begin
            if (req.go) begin
                busy    <= 1'b1;
                op_q    <= req.op;
                opnd_q  <= operand;
                step_q  <= '0;
                carry_q <= 1'b0;
            end
        end else begin
            if (shift_d) begin
                d_reg <= {new_bit, d_reg[WIDTH-1:1]};
            end else begin
                a_reg <= {new_bit, a_reg[WIDTH-1:1]};
            end
            opnd_q  <= opnd_q >> 1;
            carry_q <= (op_q == OP_INCREMENT) ? add_out[1] : 1'b0;
            step_q  <= step_q + 1'b1;
            if (step_q == LAST) begin
                busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/psl_display.sv
module psl_display #(
    parameter int WIDTH = 16
) (
    input  logic             show_bus,
    input  logic [WIDTH-1:0] panel_addr,
    input  logic [WIDTH-1:0] panel_data,
    input  logic [WIDTH-1:0] bus_addr,
    input  logic [WIDTH-1:0] bus_data,
    output logic [WIDTH-1:0] led_addr,
    output logic [WIDTH-1:0] led_data
);

    always_comb begin
        if (show_bus) begin
            led_addr = bus_addr;
            led_data = bus_data;
        end else begin
            led_addr = panel_addr;
            led_data = panel_data;
        end
    end

endmodule

// File: rtl/panel_switch_loader.sv
module panel_switch_loader
    import psl_pkg::*;
#(
    parameter int WIDTH      = PSL_WIDTH,
    parameter int SEL_CYCLES = PSL_SEL_CYCLES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sense_en_n,
    input  logic [WIDTH-1:0] addr_keys,
    input  logic [WIDTH-1:0] data_keys,
    input  logic             inc_one,
    input  logic             inc_two,
    input  logic             disp_bus,
    input  logic [WIDTH-1:0] bus_addr,
    input  logic [WIDTH-1:0] bus_data,
    output logic             addr_sel,
    output logic             data_sel,
    output logic             shift_addr,
    output logic             shift_data,
    output logic             busy,
    output logic [WIDTH-1:0] panel_addr,
    output logic [WIDTH-1:0] panel_data,
    output logic [WIDTH-1:0] led_addr,
    output logic [WIDTH-1:0] led_data
);

    localparam logic [WIDTH-1:0] ADD_ONE = WIDTH'(1);
    localparam logic [WIDTH-1:0] ADD_TWO = WIDTH'(2);

    logic [WIDTH-1:0] addr_rise;
    logic [WIDTH-1:0] data_rise;
    logic             sense_ok;
    logic             start_addr;
    logic             start_data;
    logic             start_inc;
    psl_req_t         req;
    logic [WIDTH-1:0] operand;

    psl_key_sync #(.WIDTH(WIDTH)) u_addr_sync (
        .clk  (clk),
        .rst  (rst),
        .keys (addr_keys),
        .rise (addr_rise)
    );

    psl_key_sync #(.WIDTH(WIDTH)) u_data_sync (
        .clk  (clk),
        .rst  (rst),
        .keys (data_keys),
        .rise (data_rise)
    );

    always_comb begin
        sense_ok   = !sense_en_n && !addr_sel && !data_sel && !busy;
        start_addr = sense_ok && (|addr_rise);
        start_data = sense_ok && !(|addr_rise) && (|data_rise);
        start_inc  = !addr_sel && !data_sel && !busy && !start_addr && !start_data
                     && (inc_one || inc_two);

        req.go  = start_addr || start_data || start_inc;
        req.op  = OP_LOAD_ADDR;
        operand = addr_rise;
        if (start_data) begin
            req.op  = OP_LOAD_DATA;
            operand = data_rise;
        end else if (start_inc) begin
            req.op  = OP_INCREMENT;
            operand = inc_two ? ADD_TWO : ADD_ONE;
        end
    end

    psl_oneshot #(.CYCLES(SEL_CYCLES)) u_addr_shot (
        .clk        (clk),
        .rst        (rst),
        .fire       (start_addr),
        .hold_clear (data_sel),
        .active     (addr_sel)
    );

    psl_oneshot #(.CYCLES(SEL_CYCLES)) u_data_shot (
        .clk        (clk),
        .rst        (rst),
        .fire       (start_data),
        .hold_clear (addr_sel),
        .active     (data_sel)
    );

    psl_serial_engine #(.WIDTH(WIDTH)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .operand (operand),
        .busy    (busy),
        .shift_a (shift_addr),
        .shift_d (shift_data),
        .a_reg   (panel_addr),
        .d_reg   (panel_data)
    );

    psl_display #(.WIDTH(WIDTH)) u_display (
        .show_bus   (disp_bus),
        .panel_addr (panel_addr),
        .panel_data (panel_data),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .led_addr   (led_addr),
        .led_data   (led_data)
    );

    initial begin
        if (SEL_CYCLES < WIDTH) begin
            $error("select pulse shorter than one shift burst");
        end
    end

endmodule

// File: rtl/psl_checker.sv
module psl_checker #(
    parameter int WIDTH      = 16,
    parameter int SEL_CYCLES = 355000
) (
    input logic             clk,
    input logic             rst,
    input logic             addr_sel,
    input logic             data_sel,
    input logic             shift_addr,
    input logic             shift_data,
    input logic [WIDTH-1:0] panel_addr,
    input logic [WIDTH-1:0] panel_data
);

    int   sel_run;
    int   pulse_run;
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_run   <= 0;
            pulse_run <= 0;
            armed     <= 1'b1;
        end else begin
            sel_run   <= addr_sel ? sel_run + 1 : 0;
            pulse_run <= (shift_addr || shift_data) ? pulse_run + 1 : 0;
        end
    end

    p_lockout_r3: assert property (@(posedge clk) disable iff (rst)
        !(addr_sel && data_sel));

    p_sel_width_r2: assert property (@(posedge clk) disable iff (rst)
        (!addr_sel && sel_run != 0) |-> (sel_run == SEL_CYCLES));

    p_burst_len_r4: assert property (@(posedge clk) disable iff (rst)
        (!shift_addr && !shift_data && pulse_run != 0) |-> (pulse_run == WIDTH));

    p_one_target_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({shift_addr, shift_data}));

    p_data_in_sel_r5: assert property (@(posedge clk) disable iff (rst)
        shift_data |-> data_sel);

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (armed && !shift_addr) |=> $stable(panel_addr));

    p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && !shift_data) |=> $stable(panel_data));

endmodule

bind panel_switch_loader psl_checker #(
    .WIDTH      (WIDTH),
    .SEL_CYCLES (SEL_CYCLES)
) u_psl_checker (
    .clk        (clk),
    .rst        (rst),
    .addr_sel   (addr_sel),
    .data_sel   (data_sel),
    .shift_addr (shift_addr),
    .shift_data (shift_data),
    .panel_addr (panel_addr),
    .panel_data (panel_data)
);

// File: tb/tb_panel_switch_loader.sv
module tb_panel_switch_loader;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int SEL        = 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sense_en_n = 1'b0;
    logic [W-1:0] addr_keys = '0;
    logic [W-1:0] data_keys = '0;
    logic         inc_one = 1'b0;
    logic         inc_two = 1'b0;
    logic         disp_bus = 1'b0;
    logic [W-1:0] bus_addr = '0;
    logic [W-1:0] bus_data = '0;
    logic         addr_sel, data_sel, shift_addr, shift_data, busy;
    logic [W-1:0] panel_addr, panel_data, led_addr, led_data;

    panel_switch_loader #(.WIDTH(W), .SEL_CYCLES(SEL)) dut (
        .clk(clk), .rst(rst), .sense_en_n(sense_en_n),
        .addr_keys(addr_keys), .data_keys(data_keys),
        .inc_one(inc_one), .inc_two(inc_two), .disp_bus(disp_bus),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .addr_sel(addr_sel), .data_sel(data_sel),
        .shift_addr(shift_addr), .shift_data(shift_data), .busy(busy),
        .panel_addr(panel_addr), .panel_data(panel_data),
        .led_addr(led_addr), .led_data(led_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference model
    logic [W-1:0] ha1, ha2, ha3, hd1, hd2, hd3;
    int           a_left, d_left, s_left;
    bit           s_to_data;
    logic [W-1:0] m_addr, m_data;
    // scenario monitors
    int           addr_pulses, data_pulses, addr_rises, data_rises, sel_len, last_sel_len;
    logic         prev_asel, prev_dsel;

    always @(posedge clk) begin
        logic [W-1:0] a_new, d_new;
        bit idle, ok, sa, sd, si;
        if (rst) begin
            ha1 = '0; ha2 = '0; ha3 = '0; hd1 = '0; hd2 = '0; hd3 = '0;
            a_left = 0; d_left = 0; s_left = 0; s_to_data = 0;
            m_addr = '0; m_data = '0;
        end else begin
            a_new = ha2 & ~ha3;
            d_new = hd2 & ~hd3;
            idle  = (a_left == 0) && (d_left == 0) && (s_left == 0);
            ok    = !sense_en_n && idle;
            sa    = ok && (a_new != 0);
            sd    = ok && (a_new == 0) && (d_new != 0);
            si    = idle && !sa && !sd && (inc_one || inc_two);
            ha3 = ha2; ha2 = ha1; ha1 = addr_keys;
            hd3 = hd2; hd2 = hd1; hd1 = data_keys;
            if (sa) a_left = SEL; else if (a_left > 0) a_left--;
            if (sd) d_left = SEL; else if (d_left > 0) d_left--;
            if (sa || sd || si) begin
                s_left    = W;
                s_to_data = sd;
                if (sa) m_addr = m_addr ^ a_new;
                if (sd) m_data = m_data ^ d_new;
                if (si) m_addr = m_addr + (inc_two ? 16'd2 : 16'd1);
            end else if (s_left > 0) begin
                s_left--;
            end
        end
        #(CLK_PERIOD/4);
        check(addr_sel === (a_left > 0), "R2 per-clock addr_sel", addr_sel, a_left > 0);
        check(data_sel === (d_left > 0), "R3 per-clock data_sel", data_sel, d_left > 0);
        check(busy === (s_left > 0), "R4 per-clock busy", busy, s_left > 0);
        check(shift_addr === (s_left > 0 && !s_to_data), "R4 per-clock shift_addr", shift_addr, s_left > 0 && !s_to_data);
        check(shift_data === (s_left > 0 && s_to_data), "R5 per-clock shift_data", shift_data, s_left > 0 && s_to_data);
        if (s_left == 0) begin
            check(panel_addr === m_addr, "R4 per-clock panel_addr", panel_addr, m_addr);
            check(panel_data === m_data, "R5 per-clock panel_data", panel_data, m_data);
        end
        check(led_addr === (disp_bus ? bus_addr : panel_addr), "R7 per-clock led_addr", led_addr, disp_bus ? bus_addr : panel_addr);
        check(led_data === (disp_bus ? bus_data : panel_data), "R7 per-clock led_data", led_data, disp_bus ? bus_data : panel_data);
        if (!rst) begin
            if (shift_addr) addr_pulses++;
            if (shift_data) data_pulses++;
            if (addr_sel && !prev_asel) addr_rises++;
            if (data_sel && !prev_dsel) data_rises++;
            if (addr_sel) sel_len++;
            else if (prev_asel) begin last_sel_len = sel_len; sel_len = 0; end
        end
        prev_asel = addr_sel;
        prev_dsel = data_sel;
    end

    task automatic clear_mon();
        addr_pulses = 0; data_pulses = 0; addr_rises = 0; data_rises = 0;
        sel_len = 0; last_sel_len = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (addr_sel || data_sel || busy);
        @(negedge clk);
    endtask

    task automatic touch(input logic [W-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        addr_keys = a; data_keys = d;
        repeat (3) @(negedge clk);
        addr_keys = '0; data_keys = '0;
    endtask

    task automatic bump(input bit one, input bit two);
        @(negedge clk);
        inc_one = one; inc_two = two;
        @(negedge clk);
        inc_one = 1'b0; inc_two = 1'b0;
        wait_idle();
    endtask

    initial begin
        prev_asel = 0; prev_dsel = 0;
        clear_mon();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(panel_addr === '0 && panel_data === '0, "R10 registers after reset", {panel_addr, panel_data}, 0);
        check({addr_sel, data_sel, shift_addr, shift_data} === 4'b0, "R10 controls after reset",
              {addr_sel, data_sel, shift_addr, shift_data}, 0);

        // R2 / R4: address closure on key 3
        clear_mon();
        touch(16'h0008, '0);
        wait_idle();
        check(last_sel_len == SEL, "R2 addr_sel width", last_sel_len, SEL);
        check(addr_pulses == W && data_pulses == 0, "R4 shift burst length", addr_pulses, W);
        check(panel_addr === 16'h0008, "R4 address after load", panel_addr, 16'h0008);

        // R1: sensing disabled
        clear_mon();
        sense_en_n = 1'b1;
        touch('0, 16'h0010);
        repeat (6) @(negedge clk);
        check(data_rises == 0 && panel_data === 16'h0000, "R1 closure ignored when disabled", panel_data, 0);
        sense_en_n = 1'b0;
        repeat (3) @(negedge clk);

        // R3: data closure during active address select
        clear_mon();
        touch(16'h0001, '0);
        touch('0, 16'h00F0);
        wait_idle();
        check(data_rises == 0 && panel_data === 16'h0000, "R3 data closure locked out", panel_data, 0);
        check(panel_addr === 16'h0009, "R3 address load unaffected", panel_addr, 16'h0009);

        // R5: data closure on key 15
        clear_mon();
        touch('0, 16'h8000);
        wait_idle();
        check(data_pulses == W && addr_pulses == 0, "R5 data burst length", data_pulses, W);
        check(panel_data === 16'h8000, "R5 data after load", panel_data, 16'h8000);

        // R9: both groups in the same cycle
        clear_mon();
        touch(16'h0002, 16'h0001);
        wait_idle();
        check(panel_addr === 16'h000B && panel_data === 16'h8000 && data_rises == 0,
              "R9 address group served first", {panel_addr, panel_data}, {16'h000B, 16'h8000});

        // R6: increments
        bump(1, 0);
        check(panel_addr === 16'h000C, "R6 add one", panel_addr, 16'h000C);
        bump(0, 1);
        check(panel_addr === 16'h000E, "R6 add two", panel_addr, 16'h000E);
        bump(1, 1);
        check(panel_addr === 16'h0010, "R6 add two wins", panel_addr, 16'h0010);
        touch(16'hFFEF, '0);
        wait_idle();
        check(panel_addr === 16'hFFFF, "R4 load of many keys", panel_addr, 16'hFFFF);
        clear_mon();
        bump(1, 0);
        check(panel_addr === 16'h0000 && addr_pulses == W, "R6 carry wraps all ones", panel_addr, 16'h0000);
        bump(0, 1);
        check(panel_addr === 16'h0002, "R6 add two from zero", panel_addr, 16'h0002);

        // R8: held key triggers once
        clear_mon();
        @(negedge clk);
        addr_keys = 16'h0001;
        repeat (3 * SEL) @(negedge clk);
        check(addr_rises == 1, "R8 single trigger while held", addr_rises, 1);
        check(panel_addr === 16'h0003, "R8 single toggle while held", panel_addr, 16'h0003);
        addr_keys = '0;
        repeat (4) @(negedge clk);

        // R7: display source
        bus_addr = 16'hA5C3; bus_data = 16'h1234; disp_bus = 1'b1;
        @(negedge clk);
        check(led_addr === 16'hA5C3 && led_data === 16'h1234, "R7 bus shown", {led_addr, led_data}, {16'hA5C3, 16'h1234});
        disp_bus = 1'b0;
        @(negedge clk);
        check(led_addr === panel_addr && led_data === 16'h8000, "R7 panel shown", {led_addr, led_data}, {panel_addr, 16'h8000});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule